// File: doc/BRIEF.md
# Telecom Bus Time-Slot Receiver

This block sits on the receive side of an 8-bit parallel telecom bus that carries three STS-1 signals interleaved one byte at a time. Each bus clock brings one data byte, a parity bit and three timing markers. The markers are payload (SPE), a combined pointer marker that is high on J0, J1 and V1 bytes, and a V1-only marker. The block takes the time slot chosen by configuration and passes its bytes on. Each byte leaves one clock later with a valid strobe and with flags for payload, J1 and V1.

The block keeps a slot counter that steps 0, 1, 2. A J0 byte is a pointer-marker byte with both SPE and V1 low. A J0 byte always belongs to slot 0 and sets the counter back to that slot. No byte is reported valid before the first J0. Every bus byte also has its parity checked, with the sense set by configuration. A parity error gives a one-cycle pulse that carries the slot of the bad byte, and it sets a sticky flag that software clears.

Top module: `tbus_slot_rx`

## Requirements
- R1: While `rst_n` is low and on the first sample after reset, `out_valid`, `out_spe`, `out_j1`, `out_v1`, `par_err_pulse` and `par_err_sticky` are 0.
- R2: A byte with `mk_ptr`=1, `mk_spe`=0 and `mk_v1`=0 is a J0 byte. It belongs to slot 0, and the bytes that follow take slots 1, 2, 0, 1 and so on. Before the first J0 byte after reset, `out_valid` stays 0.
- R3: When `cfg_slot` is 0, 1 or 2 and the design is aligned, a byte of that slot gives `out_valid`=1 one clock later, with `out_data` equal to the byte. Bytes of the other slots give `out_valid`=0.
- R4: When `cfg_slot`=3, `out_valid`, `out_spe`, `out_j1` and `out_v1` stay 0.
- R5: `out_spe` is the `mk_spe` value of a selected byte, one clock later. It is 0 when `out_valid` is 0.
- R6: `out_j1` is 1 one clock after a selected byte that has `mk_ptr`=1, `mk_spe`=1 and `mk_v1`=0.
- R7: `out_v1` is 1 one clock after a selected byte that has `mk_ptr`=1 and `mk_v1`=1.
- R8: With `cfg_even`=0 the parity is odd: the XOR of `bus_data` and `bus_par` must be 1. With `cfg_even`=1 that XOR must be 0. Parity is checked on every bus byte, whatever its slot.
- R9: A parity error gives `par_err_pulse`=1 for exactly one clock, one clock after the bad byte. `par_err_slot` then holds that byte's slot number.
- R10: `par_err_sticky` goes to 1 together with the error pulse. It stays 1 until `err_clr` is sampled high in a cycle with no new error. If a new error arrives in the same cycle as `err_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 8 | Interleaved data byte |
| bus_par | input | 1 | Parity bit of `bus_data` |
| mk_spe | input | 1 | Payload marker |
| mk_ptr | input | 1 | J0/J1/V1 marker |
| mk_v1 | input | 1 | V1-only marker |
| cfg_slot | input | 2 | Selected time slot, 0 to 2 (3 disables output) |
| cfg_even | input | 1 | 1 selects even parity, 0 selects odd |
| err_clr | input | 1 | Clears the sticky parity flag |
| out_data | output | 8 | Registered data byte |
| out_valid | output | 1 | Byte of the selected slot |
| out_spe | output | 1 | Selected byte is payload |
| out_j1 | output | 1 | Selected byte is J1 |
| out_v1 | output | 1 | Selected byte is V1 |
| par_err_pulse | output | 1 | One-cycle parity error strobe |
| par_err_slot | output | 2 | Slot of the byte that raised the error |
| par_err_sticky | output | 1 | Sticky parity error flag |

## Verification
The assertions expect `cfg_slot` to stay constant while the slot is in use. They also expect the markers to be consistent: J1 and V1 bytes never arrive as J0 bytes. The stimulus builds each stream arithmetically from a byte index. It starts with one J0 byte, puts the J1 and V1 triples at fixed offsets in every slot, and reprograms the configuration only while the block is in reset. It covers every slot value, both parity senses, bytes sent before alignment, injected parity errors, and a clear that arrives in the same cycle as an error.

// File: rtl/tbus_pkg.sv
// Package for the telecom bus receiver.
// Holds the bus geometry and the slot type that the submodules share.
package tbus_pkg;
    localparam int NUM_SLOTS = 3;
    localparam int DATA_W    = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);
    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/tbus_slot_track.sv
// Slot tracker.
// Gives the time slot of the byte on the bus in the current cycle.
// A J0 byte always belongs to slot 0 and sets the counter back to it.
// Assumes one byte per clock and a bus with no gaps.
module tbus_slot_track #(
    parameter int NUM_SLOTS = tbus_pkg::NUM_SLOTS,
    parameter int SLOT_W    = tbus_pkg::SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_j0,
    output logic [SLOT_W-1:0] slot_now,
    output logic              aligned_now
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] cnt_q;
    logic              aligned_q;

    // Current slot: a J0 byte forces slot 0, otherwise the counter value.
    always_comb begin
        slot_now    = is_j0 ? '0 : cnt_q;
        aligned_now = aligned_q | is_j0;
    end

    // Step the counter modulo NUM_SLOTS and remember the first alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            aligned_q <= 1'b0;
        end else begin
            cnt_q     <= (slot_now == LAST) ? '0 : slot_now + 1'b1;
            aligned_q <= aligned_now;
        end
    end
endmodule

// File: rtl/tbus_par_check.sv
// Parity checker.
// Checks every bus byte against its parity bit with the configured sense.
// Raises a one-cycle pulse that carries the slot of the bad byte, and a
// sticky flag. The sticky flag clears on err_clr; a new error wins over it.
module tbus_par_check #(
    parameter int DATA_W = tbus_pkg::DATA_W,
    parameter int SLOT_W = tbus_pkg::SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    input  logic              even,
    input  logic              clr,
    input  logic [SLOT_W-1:0] slot,
    output logic              err_pulse,
    output logic [SLOT_W-1:0] err_slot,
    output logic              err_sticky
);
    logic err_now;

    // Odd sense expects a reduction XOR of 1, even sense expects 0.
    always_comb err_now = (^{data, par}) ^ ~even;

    // Register the pulse and the slot tag, and keep the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse  <= 1'b0;
            err_slot   <= '0;
            err_sticky <= 1'b0;
        end else begin
            err_pulse  <= err_now;
            err_slot   <= slot;
            err_sticky <= err_now | (err_sticky & ~clr);
        end
    end
endmodule

// File: rtl/tbus_slot_rx.sv
// Telecom bus time-slot receiver (top).
// Takes one of the interleaved STS-1 slots from the bus and classifies its
// bytes from the markers. Every output is registered one clock after the input.
// Assumes cfg_slot only changes while the selected slot is not in use.
module tbus_slot_rx
    import tbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_par,
    input  logic              mk_spe,
    input  logic              mk_ptr,
    input  logic              mk_v1,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_even,
    input  logic              err_clr,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_spe,
    output logic              out_j1,
    output logic              out_v1,
    output logic              par_err_pulse,
    output logic [SLOT_W-1:0] par_err_slot,
    output logic              par_err_sticky
);
    localparam slot_t SLOT_OFF = slot_t'(NUM_SLOTS);

    logic  is_j0;
    slot_t slot_now;
    logic  aligned_now;
    logic  sel;

    // J0 byte: pointer marker high outside the payload and not a V1 byte.
    always_comb is_j0 = mk_ptr & ~mk_spe & ~mk_v1;

    tbus_slot_track #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_j0      (is_j0),
        .slot_now   (slot_now),
        .aligned_now(aligned_now)
    );

    // Select: aligned, the slot matches, and the slot is a legal one.
    always_comb sel = aligned_now && (cfg_slot < SLOT_OFF) && (slot_now == cfg_slot);

    // Output stage: register the byte and its classification flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_spe   <= 1'b0;
            out_j1    <= 1'b0;
            out_v1    <= 1'b0;
        end else begin
            out_data  <= bus_data;
            out_valid <= sel;
            out_spe   <= sel & mk_spe;
            out_j1    <= sel & mk_ptr & mk_spe & ~mk_v1;
            out_v1    <= sel & mk_ptr & mk_v1;
        end
    end

    tbus_par_check #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .data      (bus_data),
        .par       (bus_par),
        .even      (cfg_even),
        .clr       (err_clr),
        .slot      (slot_now),
        .err_pulse (par_err_pulse),
        .err_slot  (par_err_slot),
        .err_sticky(par_err_sticky)
    );
endmodule

// File: rtl/tbus_slot_rx_chk.sv
// Assertion checker for tbus_slot_rx. It is bound to the top module below.
// Assumes cfg_slot is held steady while the block runs.
module tbus_slot_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_slot,
    input logic       err_clr,
    input logic       out_valid,
    input logic       out_spe,
    input logic       out_j1,
    input logic       out_v1,
    input logic       par_err_pulse,
    input logic       par_err_sticky
);
    logic past_ok;

    // Marks that at least one cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R4
    illegal_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && out_valid) |-> ($past(cfg_slot) != 2'd3));

    // R5
    spe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_spe |-> out_valid);

    // R6
    j1_in_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_j1 |-> (out_spe && out_valid));

    // R7
    v1_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_v1 |-> (out_valid && !out_j1));

    // R10
    pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_pulse |-> par_err_sticky);

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(par_err_sticky) && !$past(err_clr)) |-> par_err_sticky);
endmodule

bind tbus_slot_rx tbus_slot_rx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_slot      (cfg_slot),
    .err_clr       (err_clr),
    .out_valid     (out_valid),
    .out_spe       (out_spe),
    .out_j1        (out_j1),
    .out_v1        (out_v1),
    .par_err_pulse (par_err_pulse),
    .par_err_sticky(par_err_sticky)
);

// File: tb/test_tbus_slot_rx.sv
// Bench for tbus_slot_rx.
// Runs every slot setting against both parity senses. Each stream is
// computed from a byte index; expected values come from the requirements.
module test_tbus_slot_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_data = '0;
    logic       bus_par = 1'b0, mk_spe = 1'b0, mk_ptr = 1'b0, mk_v1 = 1'b0;
    logic [1:0] cfg_slot = '0;
    logic       cfg_even = 1'b0, err_clr = 1'b0;
    logic [7:0] out_data;
    logic       out_valid, out_spe, out_j1, out_v1;
    logic       par_err_pulse, par_err_sticky;
    logic [1:0] par_err_slot;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    tbus_slot_rx i_tbus_slot_rx (.*);

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one byte, wait one clock, and return at the next falling edge.
    task automatic put(input logic [7:0] d, input logic spe, input logic ptr,
                       input logic v1, input logic bad, input logic clr);
        bus_data = d;
        mk_spe   = spe;
        mk_ptr   = ptr;
        mk_v1    = v1;
        bus_par  = (cfg_even ? (^d) : ~(^d)) ^ bad;
        err_clr  = clr;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are idle in reset
        chk("R1 valid", out_valid, 0);
        chk("R1 sticky", par_err_sticky, 0);
        for (int sl = 0; sl < 4; sl++) begin
            for (int ev = 0; ev < 2; ev++) begin
                bit sticky_exp;
                rst_n = 1'b0;
                cfg_slot = sl[1:0];
                cfg_even = ev[0];
                put(8'h00, 0, 0, 0, 0, 0);
                rst_n = 1'b1;
                // R2: bytes before the first J0 are never valid
                for (int p = 0; p < 4; p++) begin
                    put(8'(p * 11 + 3), 1, 0, 0, 0, 0);
                    chk("R2 prealign valid", out_valid, 0);
                    chk("R1 pulse", par_err_pulse, 0);
                end
                sticky_exp = 0;
                for (int k = 0; k < 60; k++) begin
                    logic [7:0] d;
                    logic spe, ptr, v1, bad, sel;
                    d   = 8'(k * 29 + sl * 13 + ev * 7 + 5);
                    ptr = (k == 0) || (k >= 15 && k <= 17) || (k >= 27 && k <= 29);
                    v1  = (k >= 27 && k <= 29);
                    spe = (k >= 3);
                    bad = (k % 7 == 5);
                    sel = (sl != 3) && (k % 3 == sl);
                    put(d, spe, ptr, v1, bad, 0);
                    if (bad) sticky_exp = 1;
                    // R3 / R4: valid only for the chosen legal slot
                    chk(sl == 3 ? "R4 valid" : "R3 valid", out_valid, sel);
                    if (sel) chk("R3 data", out_data, d);
                    chk("R5 spe", out_spe, sel & spe);
                    chk("R6 j1", out_j1, sel & ptr & spe & ~v1);
                    chk("R7 v1", out_v1, sel & v1);
                    // R8 / R9: error pulse tagged with the slot
                    chk("R8 R9 pulse", par_err_pulse, bad);
                    if (bad) chk("R9 slot", par_err_slot, k % 3);
                    chk("R10 sticky", par_err_sticky, sticky_exp);
                end
                // R9: the pulse lasts one cycle
                put(8'h5A, 1, 0, 0, 0, 0);
                chk("R9 pulse one cycle", par_err_pulse, 0);
                chk("R10 sticky holds", par_err_sticky, 1);
                // R10: a new error in the same cycle as a clear keeps the flag set
                put(8'h3C, 1, 0, 0, 1, 1);
                chk("R10 set beats clear", par_err_sticky, 1);
                put(8'h3C, 1, 0, 0, 0, 1);
                chk("R10 clear", par_err_sticky, 0);
                put(8'h3C, 1, 0, 0, 0, 0);
                chk("R10 stays clear", par_err_sticky, 0);
            end
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule